// File: doc/BRIEF.md
# Three-Stage Instruction Front End with Relative Branch

This block is the front end of a small in-order core that runs a fixed-width 32-bit instruction stream. It owns the program counter and sends a word-aligned address to a synchronous instruction memory every cycle. Each instruction passes through three slots. The fetch slot is the memory read. The decode slot is the returned word. The execute slot holds the registered instruction together with its own address.

Branch resolution happens in execute. For an instruction at address A, the program counter already reads A+8 when the instruction executes. A branch word carries a 24-bit signed word displacement. The block sign-extends the displacement, multiplies it by four, adds it to that program counter and loads the result as the next fetch address. The two younger slots are then turned into bubbles. When the link flag is set, the block also presents A+4 as a return address so that the register file can store it.

Top module: `fe3_frontend`

## Requirements
- R1: While reset is asserted, and until the first instruction reaches execute, `ex_valid`, `br_taken` and `link_we` are low, and `imem_addr` is zero.
- R2: Fetch addresses always have their two low bits at zero. Without a redirect, each executed instruction sits at the previous executed address plus 4.
- R3: Whenever `ex_valid` is high, `ex_instr` is the memory word at `ex_pc`, and `imem_addr` equals `ex_pc + 8`.
- R4: An executed word is a branch when bits [27:25] equal 3'b101. Its target is `ex_pc + 8 + (sign_extend(bits[23:0]) << 2)`, modulo 2^PC_W. In that cycle `br_taken` is high and `br_target` shows the target. In the next cycle `imem_addr` equals the target.
- R5: After a taken branch, `ex_valid` is low in each of the next two cycles. In the third cycle it is high again and holds the target instruction.
- R6: A branch with bit 24 set raises `link_we`, with `link_addr` = `ex_pc + 4`. A branch with bit 24 clear leaves `link_we` low.
- R7: A word whose bits [27:25] are not 3'b101 never raises `br_taken` or `link_we`. Neither output is raised while `ex_valid` is low.
- R8: A branch whose target word is itself a branch is taken as soon as that word reaches execute. This includes a branch to its own address (displacement -2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| imem_addr | output | PC_W | Fetch address to the synchronous instruction memory |
| imem_rdata | input | 32 | Word read at the address presented in the previous cycle |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| ex_pc | output | PC_W | Address of the instruction in execute |
| ex_instr | output | 32 | Instruction in execute |
| br_taken | output | 1 | Branch taken this cycle; fetch redirects next cycle |
| br_target | output | PC_W | Branch destination address |
| link_we | output | 1 | Write strobe for the return address |
| link_addr | output | PC_W | Return address (address of the following instruction) |

## Verification
The bench builds the block with the default PC_W of 32 and a 1 KB memory model indexed by address bits [9:2]. With this setup, the most positive and most negative 24-bit displacements wrap the full 32-bit address space and still land on known words. Those extremes are therefore directly comparable against a reference sequence. Random programs mix short and full-range branches, with and without link, and include branch chains and self-loops. Every executed slot, every bubble pair and every redirect address is compared against an instruction-level model.

// File: rtl/fe3_pkg.sv
package fe3_pkg;
  // instruction word and branch field layout
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DISP_W    = 24;
  localparam int unsigned LINK_POS  = DISP_W;
  localparam int unsigned CLASS_LSB = DISP_W + 1;
  localparam int unsigned CLASS_W   = 3;
  localparam int unsigned DEC_W     = CLASS_LSB + CLASS_W;
  localparam logic [CLASS_W-1:0] CLASS_BRANCH = 3'b101;

  typedef struct packed {
    logic              is_branch;
    logic              with_link;
    logic [DISP_W-1:0] disp;
  } br_fields_t;

  function automatic br_fields_t split_word(input logic [DEC_W-1:0] w);
    br_fields_t f;
    f.is_branch = (w[CLASS_LSB +: CLASS_W] == CLASS_BRANCH);
    f.with_link = w[LINK_POS];
    f.disp      = w[DISP_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/fe3_pc_gen.sv
module fe3_pc_gen #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect,
  input  logic [PC_W-1:0] dest,
  output logic [PC_W-1:0] pc_q
);
  logic [PC_W-1:0] pc_d;

  // next fetch address: redirect wins over sequential step
  always_comb begin
    if (redirect) pc_d = dest;
    else          pc_d = pc_q + PC_W'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> pc_q == $past(pc_q) + PC_W'(4)); // R2
endmodule

// File: rtl/fe3_stages.sv
module fe3_stages
  import fe3_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [WORD_W-1:0] rdata,
  output logic              e_valid,
  output logic [PC_W-1:0]   e_pc,
  output logic [WORD_W-1:0] e_instr
);
  // decode slot: the word coming back from memory, tagged by its address
  logic            d_valid, d_valid_d;
  logic [PC_W-1:0] d_pc;
  logic            e_valid_d, e_load;

  always_comb begin
    d_valid_d = !flush;
    e_load    = d_valid && !flush;
    e_valid_d = e_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_pc    <= '0;
      e_valid <= 1'b0;
    end else begin
      d_valid <= d_valid_d;
      d_pc    <= fetch_pc;
      e_valid <= e_valid_d;
    end
  end

  // execute payload loads only under its clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pc    <= '0;
      e_instr <= '0;
    end else if (e_load) begin
      e_pc    <= d_pc;
      e_instr <= rdata;
    end
  end

  AST_FLUSH_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !e_valid); // R5
  AST_FLUSH_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ##1 !e_valid); // R5
  AST_EXEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (e_valid && $past(e_valid) && !$past(flush)) |-> e_pc == $past(e_pc) + PC_W'(4)); // R2
endmodule

// File: rtl/fe3_br_unit.sv
module fe3_br_unit
  import fe3_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic             ex_ok,
  input  logic [DEC_W-1:0] ex_low,
  input  logic [PC_W-1:0]  ex_addr,
  input  logic [PC_W-1:0]  pc_now,
  output logic             take,
  output logic [PC_W-1:0]  dest,
  output logic             link_en,
  output logic [PC_W-1:0]  link_val
);
  localparam int unsigned SCALED_W = DISP_W + 2;

  br_fields_t      f;
  logic [PC_W-1:0] scaled;

  always_comb f = split_word(ex_low);

  // sign-extend and scale the word displacement to a byte offset
  generate
    if (PC_W > SCALED_W) begin : g_ext
      localparam int unsigned EXT_W = PC_W - SCALED_W;
      always_comb scaled = {{EXT_W{f.disp[DISP_W-1]}}, f.disp, 2'b00};
    end else begin : g_trunc
      logic [SCALED_W-1:0] full;
      always_comb begin
        full   = {f.disp, 2'b00};
        scaled = full[PC_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    take     = ex_ok && f.is_branch;
    dest     = pc_now + scaled;
    link_en  = take && f.with_link;
    link_val = ex_addr + PC_W'(4);
  end
endmodule

// File: rtl/fe3_frontend.sv
module fe3_frontend
  import fe3_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic              ex_valid,
  output logic [PC_W-1:0]   ex_pc,
  output logic [WORD_W-1:0] ex_instr,
  output logic              br_taken,
  output logic [PC_W-1:0]   br_target,
  output logic              link_we,
  output logic [PC_W-1:0]   link_addr
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [PC_W-1:0] pc_q;

  fe3_pc_gen #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_sync),
    .redirect (br_taken),
    .dest     (br_target),
    .pc_q     (pc_q)
  );

  fe3_stages #(.PC_W(PC_W)) u_stg (
    .clk      (clk),
    .rst_n    (rst_sync),
    .flush    (br_taken),
    .fetch_pc (pc_q),
    .rdata    (imem_rdata),
    .e_valid  (ex_valid),
    .e_pc     (ex_pc),
    .e_instr  (ex_instr)
  );

  fe3_br_unit #(.PC_W(PC_W)) u_br (
    .ex_ok    (ex_valid),
    .ex_low   (ex_instr[DEC_W-1:0]),
    .ex_addr  (ex_pc),
    .pc_now   (pc_q),
    .take     (br_taken),
    .dest     (br_target),
    .link_en  (link_we),
    .link_val (link_addr)
  );

  always_comb imem_addr = pc_q;

  AST_PC_LEADS_EXEC: assert property (@(posedge clk) disable iff (!rst_sync)
    ex_valid |-> imem_addr == ex_pc + PC_W'(8)); // R3
  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_sync)
    br_taken |=> imem_addr == $past(br_target)); // R4
  AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_sync)
    link_we |-> link_addr == imem_addr - PC_W'(4)); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_sync)
    br_taken |=> !br_taken); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_sync)
    !ex_valid |-> !br_taken && !link_we); // R7
endmodule

// File: tb/sim_fe3_frontend.sv
module sim_fe3_frontend;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_rdata;
  logic            ex_valid, br_taken, link_we;
  logic [PC_W-1:0] ex_pc, br_target, link_addr;
  logic [31:0]     ex_instr;

  logic [31:0] mem [256];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  // synchronous read port: word appears one cycle after its address
  always_ff @(posedge clk) imem_rdata <= mem[imem_addr[9:2]];

  fe3_frontend #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr),
    .br_taken(br_taken), .br_target(br_target),
    .link_we(link_we), .link_addr(link_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_br(input logic [31:0] w);
    return w[27:25] == 3'b101;
  endfunction

  function automatic logic [31:0] br_dest(input logic [31:0] a, input logic [31:0] w);
    return a + 32'd8 + {{6{w[23]}}, w[23:0], 2'b00};
  endfunction

  function automatic logic [31:0] mk_br(input bit lnk, input logic [23:0] off);
    return {4'hE, 3'b101, lnk, off};
  endfunction

  function automatic logic [31:0] mk_other();
    logic [31:0] r = $urandom;
    if (r[27:25] == 3'b101) r[26] = 1'b1;
    return r;
  endfunction

  function automatic logic [23:0] pick_off(input int mode);
    int k;
    case (mode)
      0: return 24'($urandom_range(0, 80)) - 24'd40;
      1: return 24'($urandom);
      default: begin
        k = $urandom_range(0, 5);
        case (k)
          0: return 24'hFFFFFE;
          1: return 24'hFFFFFF;
          2: return 24'h000000;
          3: return 24'h000001;
          4: return 24'h7FFFFF;
          default: return 24'h800000;
        endcase
      end
    endcase
  endfunction

  task automatic fill_random(input int pct, input int mode);
    for (int i = 0; i < 256; i++) begin
      if (i >= 2 && $urandom_range(0, 99) < pct) mem[i] = mk_br(1'($urandom), pick_off(mode));
      else                                       mem[i] = mk_other();
    end
  endtask

  task automatic run_prog(input int cycles);
    logic [31:0] exp_pc, w;
    int bub = -1;
    int executed = 0;
    bit prev_br = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ex_valid, "R1 ex_valid in reset", 32'(ex_valid), 0);
    chk(imem_addr == 0, "R1 imem_addr in reset", imem_addr, 0);
    chk(!br_taken && !link_we, "R1 branch/link in reset", {br_taken, link_we}, 0);
    rst_n = 1'b1;
    exp_pc = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(imem_addr[1:0] == 2'b00, "R2 fetch alignment", imem_addr, {imem_addr[31:2], 2'b00});
      if (!ex_valid)
        chk(!br_taken && !link_we, "R7 quiet without valid", {br_taken, link_we}, 0);
      if (bub > 0) begin
        chk(!ex_valid, "R5 bubble after branch", 32'(ex_valid), 0);
        bub--;
      end else begin
        if (bub == 0) begin
          chk(ex_valid, "R5 resume third cycle", 32'(ex_valid), 1);
          bub = -1;
        end
        if (ex_valid) begin
          executed++;
          w = mem[exp_pc[9:2]];
          chk(ex_pc == exp_pc, "R2 executed address", ex_pc, exp_pc);
          chk(ex_instr == w, "R3 executed word", ex_instr, w);
          chk(imem_addr == exp_pc + 8, "R3 pc leads by 8", imem_addr, exp_pc + 8);
          if (is_br(w)) begin
            chk(br_taken, prev_br ? "R8 chained branch" : "R4 branch taken", 32'(br_taken), 1);
            chk(br_target == br_dest(exp_pc, w), "R4 branch target", br_target, br_dest(exp_pc, w));
            chk(link_we == w[24], "R6 link strobe", 32'(link_we), 32'(w[24]));
            if (w[24]) chk(link_addr == exp_pc + 4, "R6 link value", link_addr, exp_pc + 4);
            exp_pc = br_dest(exp_pc, w);
            bub = 2;
            prev_br = 1;
            @(negedge clk);
            chk(imem_addr == exp_pc, "R4 redirect address", imem_addr, exp_pc);
            chk(!ex_valid, "R5 first bubble", 32'(ex_valid), 0);
            bub = 1;
          end else begin
            chk(!br_taken && !link_we, "R7 non-branch quiet", {br_taken, link_we}, 0);
            exp_pc = exp_pc + 4;
            prev_br = 0;
          end
        end
      end
    end
    chk(executed > 0, "R3 pipeline produced work", executed, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    // directed: link branch, full-range extremes, then self-loop chain
    for (int i = 0; i < 256; i++) mem[i] = 32'hE1A0_0000;
    mem[4]  = mk_br(1'b1, 24'd3);
    mem[9]  = mk_br(1'b0, 24'h800000);
    mem[11] = mk_br(1'b1, 24'h7FFFFF);
    mem[12] = mk_br(1'b0, 24'hFFFFFE);
    run_prog(120);
    fill_random(0, 0);
    run_prog(300);
    fill_random(25, 0);
    run_prog(600);
    fill_random(50, 1);
    run_prog(600);
    fill_random(40, 2);
    run_prog(600);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule